// File: doc/BRIEF.md
# Event-Code Triggered Pulse Generator

This block sits behind a recovered frame link and turns received event codes into timed output pulses. Each valid frame carries an event code in its low byte. A code table with one entry per code value decides what that code does on this receiver. An entry selects any subset of the pulse channels and can also request an interrupt. Two receivers that hold different tables therefore respond to the same code in different ways.

Each pulse channel has its own delay, width, clock divisor and output polarity. A trigger starts the channel's divisor. After `delay` divided ticks the channel output becomes active, and it stays active for `width` divided ticks. The table and the channel settings are written through a simple write-only register port.

Top module: `evp_top`

## Requirements
- R1: After a synchronous active-low reset, every table entry is empty, every channel setting is zero, all pulse outputs are low and `irq_o` is low. A code received in that state causes no action.
- R2: Let a frame be accepted on clock edge E0, and let its table entry enable channel c. Let D be the effective divisor of c, d its delay and w its width. Channel c is then active from edge E0+1+d·D up to, but not including, edge E0+1+(d+w)·D. A channel setting is written with `ch_field` 0 for delay and 1 for width.
- R3: A table entry for a code is written through `map_data`. Bit i (i < NUM_CH) enables channel i, and bit NUM_CH requests the interrupt. Channels whose bit is clear do not react to that code.
- R4: A table entry whose interrupt bit is set makes `irq_o` high for exactly the one cycle after the edge that accepts the frame.
- R5: `ch_field` 3 writes the polarity from bit 0 of `ch_wdata`. With polarity 1 the output idles high and goes low while active.
- R6: `ch_field` 2 writes the divisor from the low bits of `ch_wdata`. A divisor of 0 or 1 counts every clock, and a divisor of N counts every N-th clock, phased from the trigger.
- R7: Event code 0x00 never causes an action, whatever its table entry holds.
- R8: A trigger that reaches a channel while its delay or pulse is still running is ignored. The running pulse keeps its timing.
- R9: A channel whose width is zero produces no pulse when triggered.
- R10: Only `frame_word[7:0]` is the event code, and the upper bits are ignored. A frame with `frame_valid` low is ignored.
- R11: With a delay of zero, the output becomes active on edge E0+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered frame clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | Frame word is valid this cycle |
| frame_word | input | FRAME_W | Received frame; low CODE_W bits are the event code |
| map_we | input | 1 | Write enable for the code table |
| map_code | input | CODE_W | Table entry to write |
| map_data | input | NUM_CH+1 | Channel enables plus interrupt bit (top) |
| ch_we | input | 1 | Write enable for a channel setting |
| ch_sel | input | SEL_W | Channel to write |
| ch_field | input | 2 | 0 delay, 1 width, 2 divisor, 3 polarity |
| ch_wdata | input | CNT_W | Setting value |
| pulse_o | output | NUM_CH | Pulse outputs after polarity |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
A corrupted table entry is visible on the edge after the frame is accepted: a wrong channel starts its delay and shows an active level d·D cycles later, or `irq_o` pulses when it should not. A wrong divisor or counter value moves the leading or trailing edge of a pulse by whole divided ticks. The bench therefore compares every output on every cycle of each trigger window against the arithmetic edge positions of R2. A missed reload after a retrigger or a zero width shows up as a pulse that is longer, shifted or present when it should be absent.

// File: rtl/evp_pkg.sv
// Shared definitions for the event pulse generator.
// Assumes: field codes are decoded by every channel identically.
package evp_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DELAY = 2'd1,
        CH_PULSE = 2'd2
    } ch_state_e;

    localparam logic [1:0] FLD_DELAY = 2'd0;
    localparam logic [1:0] FLD_WIDTH = 2'd1;
    localparam logic [1:0] FLD_DIV   = 2'd2;
    localparam logic [1:0] FLD_POL   = 2'd3;
endpackage

// File: rtl/evp_map.sv
// Code table: one entry per event code, NUM_CH channel enables plus
// an interrupt bit. Read is combinational, write is synchronous.
// Assumes: the table is small enough to live in flops (2^CODE_W entries).
module evp_map #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 8,
    localparam int DEPTH = 1 << CODE_W,
    localparam int ENT_W = NUM_CH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [ENT_W-1:0]  wr_data,
    input  logic [CODE_W-1:0] rd_code,
    output logic [ENT_W-1:0]  rd_data
);
    logic [ENT_W-1:0] tbl [DEPTH];

    // Clear the table on reset, otherwise store written entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_code] <= wr_data;
        end
    end

    // Look up the entry for the incoming code.
    always_comb rd_data = tbl[rd_code];
endmodule

// File: rtl/evp_chan.sv
// One pulse channel: holds delay, width, divisor and polarity, and runs
// a delay-then-pulse sequence on a trigger, counting divided clocks.
// Assumes: settings are stable while the channel is busy.
module evp_chan
    import evp_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_field,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             trig,
    output logic             pulse_o
);
    logic [CNT_W-1:0] delay_r, width_r, cnt;
    logic [PRE_W-1:0] div_r, pre;
    logic             pol_r;
    ch_state_e        state;
    logic             tick;

    // A divided tick falls on the last count of the divisor.
    always_comb tick = (div_r <= PRE_W'(1)) || (pre == div_r - PRE_W'(1));

    // Setting writes and the delay/pulse sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_r <= '0;
            width_r <= '0;
            div_r   <= '0;
            pol_r   <= 1'b0;
            cnt     <= '0;
            pre     <= '0;
            state   <= CH_IDLE;
        end else begin
            if (cfg_we) begin
                case (cfg_field)
                    FLD_DELAY: delay_r <= cfg_wdata;
                    FLD_WIDTH: width_r <= cfg_wdata;
                    FLD_DIV:   div_r   <= cfg_wdata[PRE_W-1:0];
                    default:   pol_r   <= cfg_wdata[0];
                endcase
            end
            case (state)
                CH_IDLE: begin
                    if (trig && width_r != '0) begin
                        pre <= '0;
                        if (delay_r == '0) begin
                            state <= CH_PULSE;
                            cnt   <= width_r;
                        end else begin
                            state <= CH_DELAY;
                            cnt   <= delay_r;
                        end
                    end
                end
                CH_DELAY: begin
                    pre <= tick ? '0 : pre + PRE_W'(1);
                    if (tick) begin
                        if (cnt == CNT_W'(1)) begin
                            if (width_r == '0) begin
                                state <= CH_IDLE;
                            end else begin
                                state <= CH_PULSE;
                                cnt   <= width_r;
                            end
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                end
                CH_PULSE: begin
                    pre <= tick ? '0 : pre + PRE_W'(1);
                    if (tick) begin
                        if (cnt == CNT_W'(1)) state <= CH_IDLE;
                        else                  cnt   <= cnt - CNT_W'(1);
                    end
                end
                default: state <= CH_IDLE;
            endcase
        end
    end

    // Apply the output polarity to the active level.
    always_comb pulse_o = (state == CH_PULSE) ^ pol_r;

    a_r9_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && trig && width_r == '0) |=> state == CH_IDLE);

    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_IDLE && trig && cnt > CNT_W'(1)) |=> state == $past(state));

    a_r2_pulse_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_PULSE && $past(state) == CH_IDLE) |-> $past(trig));

    a_r6_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_IDLE && div_r > PRE_W'(1)) |-> pre < div_r);
endmodule

// File: rtl/evp_top.sv
// Event-code pulse generator top: looks up each valid frame's code in
// the code table, registers the resulting channel triggers and interrupt,
// and fans triggers out to NUM_CH pulse channels.
// Assumes: one frame per clock at most; code 0 is the idle code.
module evp_top #(
    parameter int NUM_CH  = 4,
    parameter int CNT_W   = 32,
    parameter int PRE_W   = 16,
    parameter int CODE_W  = 8,
    parameter int FRAME_W = 16,
    localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_word,
    input  logic               map_we,
    input  logic [CODE_W-1:0]  map_code,
    input  logic [NUM_CH:0]    map_data,
    input  logic               ch_we,
    input  logic [SEL_W-1:0]   ch_sel,
    input  logic [1:0]         ch_field,
    input  logic [CNT_W-1:0]   ch_wdata,
    output logic [NUM_CH-1:0]  pulse_o,
    output logic               irq_o
);
    logic [CODE_W-1:0] code;
    logic [NUM_CH:0]   entry;
    logic              hit;
    logic [NUM_CH-1:0] trig_q;
    logic              irq_q;

    // Extract the event code and qualify it.
    always_comb begin
        code = frame_word[CODE_W-1:0];
        hit  = frame_valid && (code != '0);
    end

    evp_map #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_we),
        .wr_code (map_code),
        .wr_data (map_data),
        .rd_code (code),
        .rd_data (entry)
    );

    // Register the decoded triggers and interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            trig_q <= hit ? entry[NUM_CH-1:0] : '0;
            irq_q  <= hit && entry[NUM_CH];
        end
    end

    always_comb irq_o = irq_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        evp_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (ch_we && (ch_sel == SEL_W'(i))),
            .cfg_field (ch_field),
            .cfg_wdata (ch_wdata),
            .trig      (trig_q[i]),
            .pulse_o   (pulse_o[i])
        );
    end

    a_r7_null_code: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && code == '0) |=> (trig_q == '0 && !irq_o));

    a_r10_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> (trig_q == '0 && !irq_o));

    a_r4_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(frame_valid));
endmodule

// File: tb/sim_evp_top.sv
module sim_evp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [15:0] frame_word = '0;
    logic        map_we = 1'b0;
    logic [7:0]  map_code = '0;
    logic [4:0]  map_data = '0;
    logic        ch_we = 1'b0;
    logic [1:0]  ch_sel = '0;
    logic [1:0]  ch_field = '0;
    logic [31:0] ch_wdata = '0;
    logic [3:0]  pulse_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    int cd [4];
    int cw [4];
    int cp [4];
    int cpol [4];

    evp_top u0 (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_word(frame_word),
        .map_we(map_we), .map_code(map_code), .map_data(map_data),
        .ch_we(ch_we), .ch_sel(ch_sel), .ch_field(ch_field), .ch_wdata(ch_wdata),
        .pulse_o(pulse_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic wr_ch(input int ch, input int fld, input int val);
        @(negedge clk);
        ch_we = 1'b1; ch_sel = 2'(ch); ch_field = 2'(fld); ch_wdata = 32'(val);
        @(negedge clk);
        ch_we = 1'b0;
        case (fld)
            0: cd[ch] = val;
            1: cw[ch] = val;
            2: cp[ch] = val;
            default: cpol[ch] = val & 1;
        endcase
    endtask

    task automatic cfg_ch(input int ch, input int d, input int w, input int p, input int pol);
        wr_ch(ch, 0, d);
        wr_ch(ch, 1, w);
        wr_ch(ch, 2, p);
        wr_ch(ch, 3, pol);
    endtask

    task automatic wr_map(input int code, input logic [4:0] data);
        @(negedge clk);
        map_we = 1'b1; map_code = 8'(code); map_data = data;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    // Drive one frame, then compare every output on each cycle of the window.
    task automatic watch(input logic [15:0] word, input logic vld, input logic [3:0] emask,
                         input logic eirq, input int len, input int rk, input string tag);
        logic [3:0] exp_p;
        logic       exp_i;
        int         de;
        @(negedge clk);
        frame_word = word; frame_valid = vld;
        @(posedge clk);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (k == 0) frame_valid = 1'b0;
            for (int c = 0; c < 4; c++) begin
                de = (cp[c] == 0) ? 1 : cp[c];
                exp_p[c] = (emask[c] && cw[c] != 0 && k >= 1 + cd[c] * de
                            && k < 1 + (cd[c] + cw[c]) * de) ^ cpol[c][0];
            end
            exp_i = eirq && (k == 0);
            checks++;
            if (pulse_o !== exp_p || irq_o !== exp_i) begin
                errors++;
                $display("FAIL %s cycle %0d: pulse=%b irq=%b expected pulse=%b irq=%b",
                         tag, k, pulse_o, irq_o, exp_p, exp_i);
            end
            if (k == rk) begin
                frame_word = word; frame_valid = 1'b1;
            end else if (k == rk + 1) begin
                frame_valid = 1'b0;
            end
        end
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin
            cd[c] = 0; cw[c] = 0; cp[c] = 0; cpol[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (pulse_o !== 4'b0000 || irq_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: pulse=%b irq=%b expected pulse=0000 irq=0", pulse_o, irq_o);
        end
        rst_n = 1'b1;
        // R1: empty table after reset, channels have width zero
        watch(16'h0005, 1'b1, 4'b0000, 1'b0, 6, -1, "R1");
        cfg_ch(0, 0, 1, 0, 0);
        watch(16'h0005, 1'b1, 4'b0000, 1'b0, 6, -1, "R1");

        // R2 R6 R11: timing sweep on channel 0
        wr_map(8'h11, 5'b00001);
        for (int d = 0; d < 4; d++) begin
            for (int w = 1; w <= 2; w++) begin
                for (int p = 0; p <= 3; p++) begin
                    int de;
                    de = (p == 0) ? 1 : p;
                    cfg_ch(0, d, w, p, 0);
                    watch(16'h0011, 1'b1, 4'b0001, 1'b0, 4 + (d + w) * de, -1,
                          (d == 0) ? "R11" : (p > 1 ? "R6" : "R2"));
                end
            end
        end

        // R3: per-code channel selection
        for (int c = 0; c < 4; c++) cfg_ch(c, 1, 2, 1, 0);
        wr_map(8'h21, 5'b01010);
        wr_map(8'h22, 5'b00001);
        watch(16'h0021, 1'b1, 4'b1010, 1'b0, 7, -1, "R3");
        watch(16'h0022, 1'b1, 4'b0001, 1'b0, 7, -1, "R3");

        // R4: interrupt only, and no interrupt without the bit
        wr_map(8'h30, 5'b10000);
        watch(16'h0030, 1'b1, 4'b0000, 1'b1, 4, -1, "R4");
        watch(16'h0022, 1'b1, 4'b0001, 1'b0, 7, -1, "R4");

        // R5: inverted polarity on channel 2
        cfg_ch(2, 2, 3, 1, 1);
        wr_map(8'h40, 5'b10100);
        watch(16'h0040, 1'b1, 4'b0100, 1'b1, 9, -1, "R5");
        cfg_ch(2, 1, 2, 1, 0);

        // R7: null code never acts
        wr_map(8'h00, 5'b11111);
        watch(16'h0000, 1'b1, 4'b0000, 1'b0, 7, -1, "R7");
        watch(16'hFF00, 1'b1, 4'b0000, 1'b0, 7, -1, "R7");

        // R8: retrigger while busy is ignored
        cfg_ch(0, 2, 4, 1, 0);
        watch(16'h0022, 1'b1, 4'b0001, 1'b0, 10, 2, "R8");
        watch(16'h0022, 1'b1, 4'b0001, 1'b0, 10, 4, "R8");
        cfg_ch(0, 1, 3, 2, 0);
        watch(16'h0022, 1'b1, 4'b0001, 1'b0, 13, 3, "R8");

        // R9: width zero yields no pulse
        cfg_ch(0, 1, 0, 1, 0);
        watch(16'h0022, 1'b1, 4'b0001, 1'b0, 8, -1, "R9");
        cfg_ch(0, 0, 0, 0, 0);
        watch(16'h0022, 1'b1, 4'b0001, 1'b0, 6, -1, "R9");

        // R10: upper byte ignored, invalid frames ignored
        cfg_ch(0, 1, 2, 1, 0);
        watch(16'hAB22, 1'b1, 4'b0001, 1'b0, 7, -1, "R10");
        watch(16'h0022, 1'b0, 4'b0000, 1'b0, 7, -1, "R10");
        watch(16'h0030, 1'b0, 4'b0000, 1'b0, 4, -1, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule